// File: doc/BRIEF.md
# HDLC Frame Receiver

This block takes a serial HDLC bit stream, one bit per cycle in which the bit strobe is high. It hunts for the flag octet bit by bit. It deletes the zeros the transmitter inserted, packs the remaining bits into bytes least significant bit first, and checks the 16-bit frame check sequence over the whole frame.

Frames whose address does not match are dropped. Accepted data bytes go into a receive FIFO, 32 entries deep by default. Each entry carries three tags: first byte of the frame, last byte of the frame, and frame bad.

The two FCS bytes are not stored in the FIFO. They are presented on a separate output for the host to read. Four sticky-or-level status bits are combined with a mask into one interrupt line:

- nearly full
- overflow
- end of packet
- bad frame

Top module: `hdlc_rx`

## Requirements
- R1: Bits received before the first flag are ignored. A frame opens after the bit sequence 0,1,1,1,1,1,1,0 (first bit first), and every later flag closes the current frame and opens the next.
- R2: Inside a frame, a 0 that follows five consecutive 1s is deleted before byte assembly.
- R3: Bytes are assembled least significant bit first and written to the FIFO in order. Each entry is tagged first (on the first byte of the frame) and last (on the final data byte). While `empty_o` is low, `rd_data_o` and the tags show the oldest entry, and a cycle with `rd_en_i` high removes it.
- R4: The FCS is a CRC with polynomial x^16+x^12+x^5+1, processed least significant bit first from a preset of 0xFFFF. A frame is good only if the register holds 0xF0B8 after all bytes, including both FCS bytes. The FCS bytes are not written to the FIFO. `rx_fcs_o` shows them as {second byte, first byte}. The last entry of a frame with a wrong FCS is tagged bad.
- R5: A closed frame with fewer than four bytes (address plus one more byte, then the FCS) is bad. A three-byte frame writes its first byte tagged first, last and bad. A two-byte frame writes nothing but still raises the bad status. A frame whose bit count between flags is not a whole number of bytes is bad.
- R6: With `dual_addr_i` low, a frame is kept when its first byte equals `addr_i[7:0]` or 0xFF. Any other frame causes no FIFO write and no status change.
- R7: With `dual_addr_i` high, a frame is kept when its first two bytes equal `addr_i[7:0]` then `addr_i[15:8]`, or when the first byte is 0xFF whatever the second byte is.
- R8: Seven consecutive 1s inside a frame that already holds at least one byte is an abort. The frame ends as bad, and the receiver hunts for a flag again. Ones that follow a flag with no byte in between raise nothing.
- R9: When a byte is to be written while the FIFO is full, the byte is dropped and status bit 1 (overflow) is set.
- R10: Status bit 0 (nearly full) is high while the FIFO level is at least `nf_level_i`.
- R11: Status bit 2 (end of packet) is set when a last-tagged entry is written. Status bit 3 (bad frame) is set when a bad frame of a kept address ends. Bits 1 to 3 stay set until the matching `irq_clr_i` bit is pulsed. `irq_o` is high when any status bit and its `irq_mask_i` bit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial receive data |
| dual_addr_i | input | 1 | 1: two-byte address, 0: one-byte address |
| addr_i | input | 16 | Station address, low byte compared first |
| nf_level_i | input | 6 | Nearly-full threshold in entries |
| irq_mask_i | input | 4 | Interrupt enables per status bit |
| irq_clr_i | input | 4 | Write-one clear of sticky status bits |
| rd_en_i | input | 1 | Pop the oldest FIFO entry |
| rd_data_o | output | 8 | Oldest entry data byte |
| rd_first_o | output | 1 | Oldest entry is first of a frame |
| rd_last_o | output | 1 | Oldest entry is last of a frame |
| rd_bad_o | output | 1 | Oldest entry closes a bad frame |
| empty_o | output | 1 | FIFO empty |
| level_o | output | 6 | FIFO fill level |
| rx_fcs_o | output | 16 | FCS of the last kept frame of four or more bytes |
| irq_stat_o | output | 4 | {bad, end of packet, overflow, nearly full} |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions take for granted that every input is a known value from reset release onward. They also take for granted that a clear pulse lasts one cycle and is not held across the cycle in which the bad-frame status is checked to persist.

The bench drives every input at the falling clock edge from defined values and pulses `irq_clr_i` for exactly one cycle. Serial data is zero-stuffed by the bench itself, so flags and aborts appear only where a test places them on purpose.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY    = 16'h8408;  // x^16+x^12+x^5+1, reflected
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [7:0]  ALL_CALL    = 8'hFF;

  localparam int STAT_NF  = 0;
  localparam int STAT_OVF = 1;
  localparam int STAT_EOP = 2;
  localparam int STAT_BAD = 3;

  typedef struct packed {
    logic       bad;
    logic       last;
    logic       first;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic [15:0] crc_byte(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/hdlc_rx_bitproc.sv
// Ones run tracking: flag, abort and stuffed-zero removal.
module hdlc_rx_bitproc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic dat_vld_o,
  output logic dat_o,
  output logic flag_o,
  output logic abort_o
);
  logic [2:0] ones_q;

  always_comb begin
    flag_o    = en_i && !bit_i && (ones_q == 3'd6);
    abort_o   = en_i &&  bit_i && (ones_q == 3'd6);
    dat_o     = bit_i;
    dat_vld_o = en_i && (bit_i ? (ones_q < 3'd6) : (ones_q != 3'd5 && ones_q != 3'd6));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ones_q <= 3'd7;
    else if (en_i) ones_q <= bit_i ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
  end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [AW:0]      level_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr_q, rd_ptr_q;

  assign level_o   = wr_ptr_q - rd_ptr_q;
  assign empty_o   = (level_o == '0);
  assign full_o    = (level_o == (AW+1)'(DEPTH));
  assign rd_data_o = mem[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !full_o) mem[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i && !full_o)  wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i && !empty_o) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  p_level_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= (AW+1)'(DEPTH));
  p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !rd_en_i) |=> $stable(level_o));
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             dual_addr_i,
  input  logic [15:0]      addr_i,
  input  logic [LVL_W-1:0] nf_level_i,
  input  logic [3:0]       irq_mask_i,
  input  logic [3:0]       irq_clr_i,
  input  logic             rd_en_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_first_o,
  output logic             rd_last_o,
  output logic             rd_bad_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o,
  output logic [15:0]      rx_fcs_o,
  output logic [3:0]       irq_stat_o,
  output logic             irq_o
);
  logic dat_vld, dat, flag, abort;

  hdlc_rx_bitproc u_bitproc (
    .clk_i, .rst_ni, .en_i(bit_en_i), .bit_i,
    .dat_vld_o(dat_vld), .dat_o(dat), .flag_o(flag), .abort_o(abort)
  );

  logic        in_frame_q, match_q, allcall_q, first_pend_q;
  logic [7:0]  sr_q, d0_q, d1_q, d2_q;
  logic [2:0]  bit_cnt_q, byte_cnt_q;
  logic [15:0] crc_q, fcs_q;
  logic [3:1]  stat_q;

  logic [7:0] nbyte;
  logic       byte_done, frame_close, close_bad, push, full;
  logic       bad_evt, eop_evt, ovf_evt;
  rx_entry_t  wr_ent, rd_ent;

  always_comb begin
    nbyte       = {dat, sr_q[7:1]};
    byte_done   = in_frame_q && dat_vld && (bit_cnt_q == 3'd7);
    frame_close = in_frame_q && (flag || abort) && (byte_cnt_q != 3'd0);
    // flag contributes 7 bits to the shifter, so a whole frame leaves exactly 7
    close_bad   = abort || (byte_cnt_q < 3'd4) || (bit_cnt_q != 3'd7) || (crc_q != CRC_RESIDUE);
    push        = 1'b0;
    wr_ent      = '0;
    // three-byte delay keeps the FCS bytes out of the FIFO
    if (byte_done && byte_cnt_q >= 3'd3 && match_q) begin
      push   = 1'b1;
      wr_ent = '{bad: 1'b0, last: 1'b0, first: first_pend_q, data: d2_q};
    end else if (frame_close && match_q && byte_cnt_q >= 3'd3) begin
      push   = 1'b1;
      wr_ent = '{bad: close_bad, last: 1'b1, first: first_pend_q, data: d2_q};
    end
    bad_evt = frame_close && match_q && close_bad;
    eop_evt = push && wr_ent.last;
    ovf_evt = push && full;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q   <= 1'b0;
      match_q      <= 1'b1;
      allcall_q    <= 1'b0;
      first_pend_q <= 1'b1;
      sr_q         <= '0;
      d0_q         <= '0;
      d1_q         <= '0;
      d2_q         <= '0;
      bit_cnt_q    <= '0;
      byte_cnt_q   <= '0;
      crc_q        <= CRC_PRESET;
      fcs_q        <= '0;
      stat_q       <= '0;
    end else begin
      if (frame_close && match_q && byte_cnt_q >= 3'd4) fcs_q <= {d0_q, d1_q};
      stat_q <= (stat_q & ~irq_clr_i[3:1]) | {bad_evt, eop_evt, ovf_evt};
      if (flag) begin
        in_frame_q   <= 1'b1;
        match_q      <= 1'b1;
        allcall_q    <= 1'b0;
        first_pend_q <= 1'b1;
        bit_cnt_q    <= '0;
        byte_cnt_q   <= '0;
        crc_q        <= CRC_PRESET;
      end else if (abort) begin
        in_frame_q <= 1'b0;
      end else if (in_frame_q && dat_vld) begin
        sr_q      <= nbyte;
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (byte_done) begin
          d0_q       <= nbyte;
          d1_q       <= d0_q;
          d2_q       <= d1_q;
          byte_cnt_q <= (byte_cnt_q == 3'd4) ? 3'd4 : byte_cnt_q + 3'd1;
          crc_q      <= crc_byte(crc_q, nbyte);
          if (push) first_pend_q <= 1'b0;
          if (byte_cnt_q == 3'd0) begin
            allcall_q <= (nbyte == ALL_CALL);
            match_q   <= (nbyte == ALL_CALL) || (nbyte == addr_i[7:0]);
          end else if (byte_cnt_q == 3'd1 && dual_addr_i) begin
            match_q <= match_q && (allcall_q || nbyte == addr_i[15:8]);
          end
        end
      end
    end
  end

  hdlc_rx_fifo #(.DEPTH(DEPTH), .WIDTH($bits(rx_entry_t))) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i(push), .wr_data_i(wr_ent),
    .rd_en_i, .rd_data_o(rd_ent),
    .empty_o, .full_o(full), .level_o
  );

  assign rd_data_o  = rd_ent.data;
  assign rd_first_o = rd_ent.first;
  assign rd_last_o  = rd_ent.last;
  assign rd_bad_o   = rd_ent.bad;
  assign rx_fcs_o   = fcs_q;
  assign irq_stat_o = {stat_q, level_o >= nf_level_i};
  assign irq_o      = |(irq_stat_o & irq_mask_i);

  p_ovf_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> irq_stat_o[STAT_OVF]);
  p_eop_sets_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_evt |=> irq_stat_o[STAT_EOP]);
  p_bad_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o[STAT_BAD] && !irq_clr_i[STAT_BAD]) |=> irq_stat_o[STAT_BAD]);
  p_abort_hunt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort && in_frame_q) |=> !in_frame_q);
  p_flag_opens_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag |=> (in_frame_q && byte_cnt_q == 3'd0 && bit_cnt_q == 3'd0));
endmodule

// File: tb/hdlc_rx_test.sv
`timescale 1ns/1ps
module hdlc_rx_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bit_en_i = 1'b0, bit_i = 1'b0, dual_addr_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0] addr_i = 16'h005A;
  logic [5:0]  nf_level_i = 6'd16;
  logic [3:0]  irq_mask_i = 4'h0, irq_clr_i = 4'h0;
  logic [7:0]  rd_data_o;
  logic        rd_first_o, rd_last_o, rd_bad_o, empty_o, irq_o;
  logic [5:0]  level_o;
  logic [15:0] rx_fcs_o;
  logic [3:0]  irq_stat_o;

  int checks = 0, errors = 0, tx_ones = 0;
  bit done = 0;
  logic [7:0]  fb [64];
  logic [15:0] exp_fcs;

  always #2.5 clk_i = ~clk_i;

  hdlc_rx uut (.*);

  // {len[21:18], addr byte[17:10], payload seed[9:2], corrupt[1], accept[0]}
  localparam logic [21:0] VEC [6] = '{
    {4'd4, 8'h5A, 8'h10, 1'b0, 1'b1},
    {4'd6, 8'hFF, 8'h7E, 1'b0, 1'b1},
    {4'd5, 8'h33, 8'h20, 1'b0, 1'b0},
    {4'd4, 8'h5A, 8'h40, 1'b1, 1'b1},
    {4'd8, 8'h5A, 8'hF8, 1'b0, 1'b1},
    {4'd2, 8'h5A, 8'hFE, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk_i); bit_en_i = 1'b1; bit_i = b;
    @(negedge clk_i); bit_en_i = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(0); for (int i = 0; i < 6; i++) send_bit(1); send_bit(0);
    tx_ones = 0;
  endtask

  task automatic send_sbit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_sbit(b[i]);
  endtask

  task automatic send_frame(input int n, input bit corrupt, input int extra);
    logic [15:0] c = 16'hFFFF;
    send_flag();
    for (int i = 0; i < n; i++) begin send_byte(fb[i]); c = crc_upd(c, fb[i]); end
    exp_fcs = ~c ^ {15'd0, corrupt};
    send_byte(exp_fcs[7:0]);
    send_byte(exp_fcs[15:8]);
    for (int i = 0; i < extra; i++) send_sbit(1);
    send_flag();
    repeat (2) @(negedge clk_i);
  endtask

  task automatic clr_all();
    @(negedge clk_i); irq_clr_i = 4'hF;
    @(negedge clk_i); irq_clr_i = 4'h0;
  endtask

  // pop n entries; expected {bad,last,first,data}
  task automatic pop_check(input string req, input int n, input bit has_last, input bit bad_last);
    for (int i = 0; i < n; i++) begin
      logic lst;
      lst = has_last && (i == n - 1);
      chk(req, {rd_bad_o, rd_last_o, rd_first_o, rd_data_o},
          {lst && bad_last, lst, i == 0, fb[i]});
      rd_en_i = 1'b1;
      @(negedge clk_i); rd_en_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("reset level", level_o, 0);
    chk("reset empty", empty_o, 1);
    chk("reset stat", irq_stat_o, 0);
    chk("reset irq", irq_o, 0);
    chk("reset fcs", rx_fcs_o, 0);

    // R1: noise before any flag writes nothing
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(0); send_bit(1);
    repeat (2) @(negedge clk_i);
    chk("R1 pre-flag noise", level_o, 0);

    // table: R2 stuffing in payloads, R3 order/tags, R4 FCS, R6 single address
    foreach (VEC[k]) begin
      int n;
      n = int'(VEC[k][21:18]);
      fb[0] = VEC[k][17:10];
      for (int i = 1; i < n; i++) fb[i] = VEC[k][9:2] + 8'(i);
      clr_all();
      send_frame(n, VEC[k][1], 0);
      chk("R6 kept level", level_o, VEC[k][0] ? n : 0);
      chk("R11 eop", irq_stat_o[2], VEC[k][0]);
      chk("R4 bad tag on fcs", irq_stat_o[3], VEC[k][1]);
      if (VEC[k][0]) begin
        chk("R4 rx fcs", rx_fcs_o, exp_fcs);
        pop_check("R3 R2 entry", n, 1, VEC[k][1]);
      end
    end

    // R8: mark idle after a frame is not an abort
    clr_all();
    fb[0] = 8'h5A; fb[1] = 8'h01; fb[2] = 8'h02;
    send_frame(3, 0, 0);
    for (int i = 0; i < 10; i++) send_bit(1);
    chk("R8 idle ones not bad", irq_stat_o[3], 0);
    pop_check("R8 frame before idle", 3, 1, 0);

    // R8: abort after three bytes
    clr_all();
    send_flag(); send_byte(8'h5A); send_byte(8'h11); send_byte(8'h22);
    for (int i = 0; i < 8; i++) send_bit(1);
    repeat (2) @(negedge clk_i);
    chk("R8 abort bad", irq_stat_o[3], 1);
    fb[0] = 8'h5A;
    pop_check("R8 abort entry", 1, 1, 1);

    // R5: two-byte frame
    clr_all();
    send_flag(); send_byte(8'h5A); send_byte(8'h11); send_flag();
    repeat (2) @(negedge clk_i);
    chk("R5 short no write", level_o, 0);
    chk("R5 short bad", irq_stat_o[3], 1);

    // R5: three trailing bits make the frame not a whole number of bytes
    clr_all();
    fb[0] = 8'h5A; fb[1] = 8'h31; fb[2] = 8'h32; fb[3] = 8'h33;
    send_frame(4, 0, 3);
    chk("R5 odd bits bad", irq_stat_o[3], 1);
    chk("R5 odd bits level", level_o, 5);
    repeat (4) begin rd_en_i = 1'b1; @(negedge clk_i); rd_en_i = 1'b0; end
    chk("R5 odd bits last tag", {rd_bad_o, rd_last_o}, 2'b11);
    rd_en_i = 1'b1; @(negedge clk_i); rd_en_i = 1'b0;

    // R7: dual address
    dual_addr_i = 1'b1; addr_i = 16'hC35A;
    clr_all();
    fb[0] = 8'h5A; fb[1] = 8'hC3; fb[2] = 8'h01; fb[3] = 8'h02;
    send_frame(4, 0, 0);
    pop_check("R7 dual match", 4, 1, 0);
    clr_all();
    fb[0] = 8'h5A; fb[1] = 8'h00; fb[2] = 8'h01;
    send_frame(3, 0, 0);
    chk("R7 dual mismatch level", level_o, 0);
    chk("R7 dual mismatch stat", irq_stat_o, 0);
    fb[0] = 8'hFF; fb[1] = 8'h12; fb[2] = 8'h34;
    send_frame(3, 0, 0);
    pop_check("R7 dual all-call", 3, 1, 0);
    dual_addr_i = 1'b0; addr_i = 16'h005A;

    // R9: overflow
    clr_all();
    fb[0] = 8'h5A;
    for (int i = 1; i < 40; i++) fb[i] = 8'(i * 3);
    send_frame(40, 0, 0);
    chk("R9 full level", level_o, 32);
    chk("R9 overflow stat", irq_stat_o[1], 1);
    pop_check("R9 kept entries", 32, 0, 0);
    chk("R9 drained", empty_o, 1);

    // R10 nearly full, R11 mask and clear
    clr_all();
    nf_level_i = 6'd5;
    for (int i = 1; i < 6; i++) fb[i] = 8'(i);
    send_frame(6, 0, 0);
    chk("R10 nearly full set", irq_stat_o[0], 1);
    nf_level_i = 6'd7;
    @(negedge clk_i);
    chk("R10 nearly full clear", irq_stat_o[0], 0);
    irq_mask_i = 4'b0100;
    @(negedge clk_i);
    chk("R11 masked eop irq", irq_o, 1);
    irq_mask_i = 4'b1011;
    @(negedge clk_i);
    chk("R11 mask blocks", irq_o, 0);
    @(negedge clk_i); irq_clr_i = 4'b0100;
    @(negedge clk_i); irq_clr_i = 4'h0;
    chk("R11 clear eop", irq_stat_o[2], 0);
    pop_check("R10 entries", 6, 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule